// File: doc/BRIEF.md
# NAND Address Cycle Generator

This block turns a column offset and a page number into the ordered address bytes that a NAND flash device expects during its address phase. It covers devices with 512-byte and 2048-byte pages, on either an 8-bit or a 16-bit data bus. The operation type selects the layout. Read and program send column bytes followed by page bytes. Erase sends page bytes only. The identification read sends a single byte. Status and reset send no address bytes at all.

The number of address cycles comes from the page size and the device capacity. The capacity is given as the base-2 logarithm of the device size in bytes. A start pulse captures the column, the page, the operation and the configuration. The bytes are then offered, least significant first, to a downstream pin driver over a valid/ready handshake. A one-cycle done pulse follows the last accepted byte. The block does not drive the flash pins and does not move commands or data.

Top module: `nand_addr_seq`

## Requirements
- R1: For read/program on a small-page device (`large_page`=0), byte 0 is the low 8 bits of the column. Byte k (k≥1) is page bits [8k-1:8k-8].
- R2: For read/program on a large-page device (`large_page`=1), the column is masked to 12 bits. Byte 0 is column bits [7:0] and byte 1 is column bits [11:8], zero-extended. Byte k (k≥2) is page bits [8(k-2)+7:8(k-2)], so a fifth byte carries page bits [23:16].
- R3: For erase (`op`=3), only page bytes are sent. Byte k is page bits [8k+7:8k].
- R4: With `bus16`=1, the column is shifted right by one before packing for read/program. The identification read is never shifted.
- R5: On small-page devices, read/program uses 4 cycles and erase uses 3 when `cap_log2`>25. They use 3 and 2 when `cap_log2`>17. Otherwise they use 2 and 1.
- R6: On large-page devices, read/program uses 5 cycles and erase uses 3 when `cap_log2`>27. They use 4 and 2 when `cap_log2`>19. Otherwise they use 3 and 1.
- R7: An operation with no address (`op`=0) offers no byte. It raises `done` in the cycle after the start.
- R8: The identification read (`op`=1) offers exactly one byte: the low 8 bits of the column.
- R9: A byte is transferred on a clock edge where `byte_valid` and `byte_ready` are both high. While `byte_valid` is high and `byte_ready` is low, `byte_out` and `byte_valid` hold.
- R10: `done` is a single-cycle pulse in the cycle after the last byte is accepted, and `byte_valid` is low while `done` is high.
- R11: The inputs are captured when `start` is high and no byte is pending. A `start` while bytes are pending has no effect, and later changes to the inputs do not alter the bytes.
- R12: After reset, `byte_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture inputs and begin a sequence |
| op | input | 2 | 0 none, 1 identification, 2 read/program, 3 erase |
| large_page | input | 1 | 1 for 2048-byte pages, 0 for 512-byte pages |
| bus16 | input | 1 | 1 when the device data bus is 16 bits wide |
| cap_log2 | input | CAP_W | log2 of device capacity in bytes |
| column | input | COL_W | Column offset in bytes |
| page | input | PAGE_W | Page number |
| byte_ready | input | 1 | Downstream accepts the offered byte |
| byte_out | output | 8 | Address byte offered |
| byte_valid | output | 1 | `byte_out` is valid |
| done | output | 1 | Pulse after the last byte (or after start for zero bytes) |

## Verification
The bench sweeps every operation, both page sizes and both bus widths. It runs each combination across capacities on both sides of each threshold, so an off-by-one compare (≥ instead of >) shows up as a wrong byte count at exactly 17, 19, 25 or 27. Column values with bits above bit 11 set expose a missing 12-bit mask on large pages. Applying the halving to the identification read, or forgetting it on read/program, corrupts byte 0.

Runs with a stalled `byte_ready` catch a shifter that advances without a handshake, which would skip bytes. A start injected mid-sequence, with changed inputs, catches a design that re-captures while busy. A design that pulses `done` early, or never pulses it for zero-byte operations, fails the byte count or times out on that run.

// File: rtl/nand_addr_pkg.sv
package nand_addr_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_ID    = 2'd1,
    OP_RW    = 2'd2,
    OP_ERASE = 2'd3
  } addr_op_e;
endpackage

// File: rtl/nand_addr_cyc_cfg.sv
module nand_addr_cyc_cfg
  import nand_addr_pkg::*;
#(
  parameter int CAP_W       = 6,
  parameter int CNT_W       = 3,
  parameter int SP_HI_LOG2  = 25,
  parameter int SP_MID_LOG2 = 17,
  parameter int LP_HI_LOG2  = 27,
  parameter int LP_MID_LOG2 = 19
) (
  input  addr_op_e         op,
  input  logic             large_page,
  input  logic [CAP_W-1:0] cap_log2,
  output logic [CNT_W-1:0] n_cyc
);
  localparam logic [CAP_W-1:0] SP_HI  = CAP_W'(SP_HI_LOG2);
  localparam logic [CAP_W-1:0] SP_MID = CAP_W'(SP_MID_LOG2);
  localparam logic [CAP_W-1:0] LP_HI  = CAP_W'(LP_HI_LOG2);
  localparam logic [CAP_W-1:0] LP_MID = CAP_W'(LP_MID_LOG2);

  logic [CNT_W-1:0] rw_n, er_n;

  always_comb begin
    if (large_page) begin
      if (cap_log2 > LP_HI)       begin rw_n = CNT_W'(5); er_n = CNT_W'(3); end
      else if (cap_log2 > LP_MID) begin rw_n = CNT_W'(4); er_n = CNT_W'(2); end
      else                        begin rw_n = CNT_W'(3); er_n = CNT_W'(1); end
    end else begin
      if (cap_log2 > SP_HI)       begin rw_n = CNT_W'(4); er_n = CNT_W'(3); end
      else if (cap_log2 > SP_MID) begin rw_n = CNT_W'(3); er_n = CNT_W'(2); end
      else                        begin rw_n = CNT_W'(2); er_n = CNT_W'(1); end
    end
  end

  always_comb begin
    unique case (op)
      OP_NONE:  n_cyc = '0;
      OP_ID:    n_cyc = CNT_W'(1);
      OP_RW:    n_cyc = rw_n;
      default:  n_cyc = er_n;
    endcase
  end
endmodule

// File: rtl/nand_addr_pack.sv
module nand_addr_pack
  import nand_addr_pkg::*;
#(
  parameter int COL_W    = 14,
  parameter int PAGE_W   = 24,
  parameter int MAX_CYC  = 5,
  parameter int LP_COL_W = 12
) (
  input  addr_op_e                 op,
  input  logic                     large_page,
  input  logic                     bus16,
  input  logic [COL_W-1:0]         column,
  input  logic [PAGE_W-1:0]        page,
  output logic [8*MAX_CYC-1:0]     vec
);
  localparam int VEC_W = 8 * MAX_CYC;
  localparam logic [COL_W-1:0] LP_MASK = COL_W'((1 << LP_COL_W) - 1);
  localparam logic [COL_W-1:0] SP_MASK = COL_W'(8'hFF);

  logic [COL_W-1:0] col_w;
  logic [VEC_W-1:0] page_ext, col_sp, col_lp, col_id;

  always_comb begin
    col_w    = bus16 ? (column >> 1) : column;
    page_ext = VEC_W'(page);
    col_sp   = VEC_W'(col_w & SP_MASK);
    col_lp   = VEC_W'(col_w & LP_MASK);
    col_id   = VEC_W'(column & SP_MASK);
  end

  always_comb begin
    unique case (op)
      OP_NONE:  vec = '0;
      OP_ID:    vec = col_id;
      OP_RW:    vec = large_page ? ((page_ext << 16) | col_lp)
                                 : ((page_ext << 8)  | col_sp);
      default:  vec = page_ext;
    endcase
  end
endmodule

// File: rtl/nand_addr_shift.sv
module nand_addr_shift #(
  parameter int MAX_CYC = 5,
  parameter int CNT_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [8*MAX_CYC-1:0] vec,
  input  logic [CNT_W-1:0]     n_cyc,
  input  logic                 byte_ready,
  output logic [7:0]           byte_out,
  output logic                 byte_valid,
  output logic                 done
);
  logic [8*MAX_CYC-1:0] sr_q;
  logic [CNT_W-1:0]     left_q;
  logic                 valid_q, done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q    <= '0;
      left_q  <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!valid_q) begin
        if (start) begin
          sr_q <= vec;
          if (n_cyc == '0) begin
            done_q <= 1'b1;
          end else begin
            valid_q <= 1'b1;
            left_q  <= n_cyc;
          end
        end
      end else if (byte_ready) begin
        if (left_q == CNT_W'(1)) begin
          valid_q <= 1'b0;
          done_q  <= 1'b1;
        end
        sr_q   <= sr_q >> 8;
        left_q <= left_q - CNT_W'(1);
      end
    end
  end

  assign byte_out   = sr_q[7:0];
  assign byte_valid = valid_q;
  assign done       = done_q;
endmodule

// File: rtl/nand_addr_seq.sv
module nand_addr_seq
  import nand_addr_pkg::*;
#(
  parameter int COL_W       = 14,
  parameter int PAGE_W      = 24,
  parameter int CAP_W       = 6,
  parameter int MAX_CYC     = 5,
  parameter int LP_COL_W    = 12,
  parameter int SP_HI_LOG2  = 25,
  parameter int SP_MID_LOG2 = 17,
  parameter int LP_HI_LOG2  = 27,
  parameter int LP_MID_LOG2 = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic              large_page,
  input  logic              bus16,
  input  logic [CAP_W-1:0]  cap_log2,
  input  logic [COL_W-1:0]  column,
  input  logic [PAGE_W-1:0] page,
  input  logic              byte_ready,
  output logic [7:0]        byte_out,
  output logic              byte_valid,
  output logic              done
);
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam int VEC_W = 8 * MAX_CYC;

  addr_op_e         op_e;
  logic [CNT_W-1:0] n_cyc;
  logic [VEC_W-1:0] vec;

  assign op_e = addr_op_e'(op);

  nand_addr_cyc_cfg #(
    .CAP_W(CAP_W), .CNT_W(CNT_W),
    .SP_HI_LOG2(SP_HI_LOG2), .SP_MID_LOG2(SP_MID_LOG2),
    .LP_HI_LOG2(LP_HI_LOG2), .LP_MID_LOG2(LP_MID_LOG2)
  ) u_cfg (
    .op(op_e), .large_page(large_page), .cap_log2(cap_log2), .n_cyc(n_cyc)
  );

  nand_addr_pack #(
    .COL_W(COL_W), .PAGE_W(PAGE_W), .MAX_CYC(MAX_CYC), .LP_COL_W(LP_COL_W)
  ) u_pack (
    .op(op_e), .large_page(large_page), .bus16(bus16),
    .column(column), .page(page), .vec(vec)
  );

  nand_addr_shift #(.MAX_CYC(MAX_CYC), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .start(start), .vec(vec), .n_cyc(n_cyc),
    .byte_ready(byte_ready), .byte_out(byte_out),
    .byte_valid(byte_valid), .done(done)
  );
endmodule

// File: rtl/nand_addr_seq_chk.sv
module nand_addr_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [1:0] op,
  input logic       byte_ready,
  input logic [7:0] byte_out,
  input logic       byte_valid,
  input logic       done
);
  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (rst)
    byte_valid && !byte_ready |=> byte_valid && $stable(byte_out)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DONE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    done |-> !byte_valid); // R10
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(byte_valid && byte_ready) || $past(start)); // R10
  AST_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
    start && !byte_valid && op == 2'd0 |=> done && !byte_valid); // R7
  AST_ID_ONE: assert property (@(posedge clk) disable iff (rst)
    start && !byte_valid && op == 2'd1 |=> byte_valid && !done); // R8
  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
    byte_valid && !byte_ready |=> !done); // R11
endmodule

bind nand_addr_seq nand_addr_seq_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .op(op), .byte_ready(byte_ready),
  .byte_out(byte_out), .byte_valid(byte_valid), .done(done)
);

// File: tb/nand_addr_seq_bench.sv
module nand_addr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 14;
  localparam int PAGE_W = 24;
  localparam int CAP_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] op = 2'd0;
  logic large_page = 1'b0, bus16 = 1'b0;
  logic [CAP_W-1:0] cap_log2 = '0;
  logic [COL_W-1:0] column = '0;
  logic [PAGE_W-1:0] page = '0;
  logic byte_ready = 1'b0;
  logic [7:0] byte_out;
  logic byte_valid, done;

  int total = 0, bad = 0, cyc = 0;
  int unsigned seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_addr_seq u_nand_addr_seq (
    .clk(clk), .rst(rst), .start(start), .op(op), .large_page(large_page),
    .bus16(bus16), .cap_log2(cap_log2), .column(column), .page(page),
    .byte_ready(byte_ready), .byte_out(byte_out), .byte_valid(byte_valid),
    .done(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int unsigned lcg();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 4;
  endfunction

  function automatic int exp_count(int o, bit lg, int cap);
    case (o)
      0: return 0;
      1: return 1;
      2: return lg ? (cap > 27 ? 5 : cap > 19 ? 4 : 3)
                   : (cap > 25 ? 4 : cap > 17 ? 3 : 2);
      default: return lg ? (cap > 27 ? 3 : cap > 19 ? 2 : 1)
                         : (cap > 25 ? 3 : cap > 17 ? 2 : 1);
    endcase
  endfunction

  function automatic int exp_byte(int o, bit lg, bit b16, int col, int pg, int k);
    int cw;
    cw = b16 ? (col >> 1) : col;
    case (o)
      1: return col % 256;
      2: if (!lg) return (k == 0) ? cw % 256 : (pg >> (8*(k-1))) % 256;
         else if (k == 0) return cw % 256;
         else if (k == 1) return (cw / 256) % 16;
         else return (pg >> (8*(k-2))) % 256;
      3: return (pg >> (8*k)) % 256;
      default: return -1;
    endcase
  endfunction

  function automatic string tag_of(int o, bit lg);
    case (o)
      0: return "R7";
      1: return "R8";
      2: return lg ? "R2" : "R1";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, expv);
    end
  endtask

  // stall: 0 always ready, 1 periodic stalls. inject: pulse start mid-run.
  task automatic run_op(int o, bit lg, bit b16, int cap, int col, int pg,
                        bit stall, bit inject);
    int n_exp, got, errs, first_bad_act, first_bad_exp, wait_c;
    bit seen_done, prev_hold, hold_err;
    logic [7:0] prev_byte;
    n_exp = exp_count(o, lg, cap);
    got = 0; errs = 0; first_bad_act = 0; first_bad_exp = 0;
    seen_done = 0; prev_hold = 0; hold_err = 0; prev_byte = '0;
    op = 2'(o); large_page = lg; bus16 = b16; cap_log2 = CAP_W'(cap);
    column = COL_W'(col); page = PAGE_W'(pg); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 40 && !seen_done; t++) begin
      if (done) begin
        seen_done = 1;
      end else begin
        if (prev_hold && (!byte_valid || byte_out != prev_byte)) hold_err = 1;
        byte_ready = stall ? ((t % 3) == 2) : 1'b1;
        if (inject && t == 1 && byte_valid) begin
          start = 1'b1;
          column = ~column;
          page = ~page;
          op = 2'd0;
        end else begin
          start = 1'b0;
        end
        prev_hold = byte_valid && !byte_ready;
        prev_byte = byte_out;
        if (byte_valid && byte_ready) begin
          if (byte_out != 8'(exp_byte(o, lg, b16, col, pg, got))) begin
            if (errs == 0) begin
              first_bad_act = byte_out;
              first_bad_exp = exp_byte(o, lg, b16, col, pg, got);
            end
            errs++;
          end
          got++;
        end
        @(negedge clk);
      end
    end
    start = 1'b0;
    byte_ready = 1'b0;
    chk(errs == 0, inject ? "R11" : (b16 ? {tag_of(o, lg), "+R4"} : tag_of(o, lg)),
        first_bad_act, first_bad_exp);
    chk(got == n_exp && seen_done, lg ? "R6 count" : "R5 count", got, n_exp);
    if (stall) chk(!hold_err, "R9 hold", int'(hold_err), 0);
    @(negedge clk);
    chk(!done, "R10 pulse", int'(done), 0);
  endtask

  initial begin
    int caps[9] = '{16, 17, 18, 19, 20, 25, 26, 27, 28};
    repeat (3) @(negedge clk);
    chk(!byte_valid && !done, "R12 reset", int'({byte_valid, done}), 0);
    rst = 1'b0;
    @(negedge clk);
    for (int o = 0; o < 4; o++)
      for (int lg = 0; lg < 2; lg++)
        for (int b = 0; b < 2; b++)
          for (int c = 0; c < 9; c++)
            run_op(o, lg[0], b[0], caps[c], int'(lcg() % 16384),
                   int'(lcg() % 16777216), (c % 2) == 1, 1'b0);
    // column with bits above 11 set, large page, both widths (R2, R4)
    run_op(2, 1'b1, 1'b0, 28, 16383, 24'hABCDEF, 1'b0, 1'b0);
    run_op(2, 1'b1, 1'b1, 28, 16383, 24'h123456, 1'b0, 1'b0);
    run_op(1, 1'b0, 1'b1, 16, 16'h00FF, 0, 1'b0, 1'b0);
    // start while busy with changed inputs (R11)
    run_op(2, 1'b1, 1'b0, 28, 1234, 24'h55AA33, 1'b1, 1'b1);
    run_op(3, 1'b0, 1'b0, 26, 77, 24'h0F1E2D, 1'b1, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule